// File: doc/BRIEF.md
# I2C Status Flag Register

This block keeps the three sticky status flags of an I2C bus interface and the interface's master interrupt flag. The bus engine sends it single-cycle event pulses: a stop condition was seen, a data register became empty, or a data register became full. It also sends level qualifiers: a frame is still being shifted, the slave address matched, and the current operating mode. A stop condition raises one of two flags. If a frame was still in progress it raises the error-stop flag; otherwise it raises the normal-stop flag. A data-register event raises the continuous-transfer flag, and the master interrupt flag rises with it in the same clock.

Software reaches the flags through a small register port. A flag can be cleared directly, but only by writing 0 to its bit after a read has returned that bit as 1. A flag can also be cleared indirectly: clearing the master interrupt flag drops both stop flags, and it drops the continuous-transfer flag when the interface is enabled. If a set event and a clear fall in the same cycle, the set takes priority. The interrupt request output is the master interrupt flag gated by an enable input.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset every flag is 0. Register 0 (`cpu_addr`=0) reads error-stop in bit 7, normal-stop in bit 6 and continuous-transfer in bit 5. Register 1 reads the master interrupt flag in bit 0. Every other bit reads 0. Read data is combinational from the current flags.
- R2: A `bus_stop` pulse while `bus_frame_busy`=1 and `bus_mode`=2'b00 (slave, I2C format) sets the error-stop flag at the next edge. In any other mode the pulse has no effect.
- R3: A `bus_stop` pulse while `bus_frame_busy`=0 and `bus_mode`=2'b00 sets the normal-stop flag at the next edge.
- R4: A write of 0 to a flag's bit clears that flag only if a strobed read returned the bit as 1 while the flag was set. Without such a read, the write leaves the flag at 1. Writing 1 to a bit never changes it. The read arm is kept until the flag clears.
- R5: A `bus_dre` or `bus_drf` pulse sets the continuous-transfer flag. In mode 2'b00 this needs `bus_addr_match`=1. In every other mode (2'b01 master, 2'b10 clocked synchronous) no qualifier is needed.
- R6: The master interrupt flag is set at the same edge as the continuous-transfer flag. It is cleared by writing 0 to bit 0 of register 1 after that bit was read as 1.
- R7: When the master interrupt flag clears, the error-stop and normal-stop flags clear at the same edge. The continuous-transfer flag also clears then, but only if `if_enable`=1.
- R8: When a set event coincides with a clear of the same flag, whether the clear is direct or linked, the flag stays 1.
- R9: `irq_out` is 1 exactly when the master interrupt flag is 1 and `irq_enable`=1.
- R10: Writes to bits 4..0 of register 0 and bits 7..1 of register 1 have no effect, and those bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_stop | input | 1 | Stop condition detected (pulse) |
| bus_frame_busy | input | 1 | A frame transfer is in progress |
| bus_dre | input | 1 | Data register became empty (pulse) |
| bus_drf | input | 1 | Data register became full (pulse) |
| bus_addr_match | input | 1 | Slave address match qualifier |
| bus_mode | input | 2 | 00 slave I2C, 01 master I2C, 10 clocked synchronous |
| if_enable | input | 1 | Interface enable |
| irq_enable | input | 1 | Interrupt request enable |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 1 | 0 status register, 1 interrupt flag register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| int_flag | output | 1 | Master interrupt flag |
| irq_out | output | 1 | Interrupt request |

## Verification
Every flag changes at the first rising edge that samples its event pulse or its write strobe. Read data and `irq_out` follow the flags in the same cycle, with no further register. The bench drives inputs 1 ns after a rising edge and takes directed samples before the following falling edge, so each sample already reflects the edge that consumed the stimulus. A behavioural reference model advances at each rising edge from the same inputs. It is compared with read data and `irq_out` at every falling edge, and that comparison also covers the cycles in which sets and clears collide.

// File: rtl/i2c_sf_pkg.sv
// Shared definitions for the I2C status flag register.
// Assumes an 8-bit register port; the bit positions below are decoded by software.
package i2c_sf_pkg;
    typedef enum logic [1:0] {
        MODE_I2C_SLAVE  = 2'b00,
        MODE_I2C_MASTER = 2'b01,
        MODE_CLK_SYNC   = 2'b10,
        MODE_RESERVED   = 2'b11
    } bus_mode_e;

    localparam int REG_W      = 8;
    localparam int NUM_STAT   = 3;            // xfer, normal-stop, error-stop
    localparam int XFER_BIT   = 5;            // lowest status bit; the others follow upward
    localparam int NORM_BIT   = XFER_BIT + 1;
    localparam int ERR_BIT    = XFER_BIT + 2;
    localparam int INT_BIT    = 0;
endpackage

// File: rtl/i2c_sf_flag_cell.sv
// One sticky flag with a "seen as 1" arm bit.
// Set wins over every clear. A direct clear needs the arm; an external clear does not.
// Assumes set_i, rd_i, wr_zero_i and ext_clr_i are single-cycle qualified strobes.
module i2c_sf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_zero_i,
    input  logic ext_clr_i,
    output logic flag_o,
    output logic clr_o
);
    logic flag_q;
    logic arm_q;

    // Clear happens only when the flag is up and no set competes.
    assign clr_o  = flag_q & ~set_i & ((wr_zero_i & arm_q) | ext_clr_i);
    assign flag_o = flag_q;

    // Flag and arm state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= set_i | (flag_q & ~clr_o);
            if (clr_o) begin
                arm_q <= 1'b0;
            end else if (rd_i && flag_q) begin
                arm_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_sf_event_sort.sv
// Turns bus engine pulses into per-flag set requests according to the mode.
// Assumes stop and data-register pulses last one cycle; purely combinational.
module i2c_sf_event_sort
    import i2c_sf_pkg::*;
(
    input  logic      stop_i,
    input  logic      busy_i,
    input  logic      dre_i,
    input  logic      drf_i,
    input  logic      match_i,
    input  bus_mode_e mode_i,
    output logic      err_set_o,
    output logic      norm_set_o,
    output logic      xfer_set_o
);
    logic slave;
    logic data_ev;

    // Classify stop and data events.
    always_comb begin
        slave      = (mode_i == MODE_I2C_SLAVE);
        data_ev    = dre_i | drf_i;
        err_set_o  = stop_i & busy_i & slave;
        norm_set_o = stop_i & ~busy_i & slave;
        xfer_set_o = data_ev & (slave ? match_i : 1'b1);
    end
endmodule

// File: rtl/i2c_status_flags.sv
// I2C status flag register: error-stop, normal-stop and continuous-transfer flags
// plus the master interrupt flag. Register 0 holds the status flags, register 1
// holds the interrupt flag in bit 0. Read data is combinational.
// Assumes one register access per cycle and single-cycle bus event pulses.
module i2c_status_flags
    import i2c_sf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_stop,
    input  logic             bus_frame_busy,
    input  logic             bus_dre,
    input  logic             bus_drf,
    input  logic             bus_addr_match,
    input  logic [1:0]       bus_mode,
    input  logic             if_enable,
    input  logic             irq_enable,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic             cpu_addr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    output logic             int_flag,
    output logic             irq_out
);
    logic                err_set, norm_set, xfer_set;
    logic [NUM_STAT-1:0] set_vec;
    logic [NUM_STAT-1:0] ext_clr_vec;
    logic [NUM_STAT-1:0] stat_flags;
    logic [NUM_STAT-1:0] stat_clr;
    logic                rd_stat, wr_stat, rd_int, wr_int;
    logic                int_q;
    logic                link_clr;
    logic                unused_wbits;

    assign unused_wbits = ^{cpu_wdata[XFER_BIT-1:1], cpu_wdata[REG_W-1:ERR_BIT+1], stat_clr};

    // Decode the register port strobes.
    always_comb begin
        rd_stat = cpu_rd & ~cpu_addr;
        wr_stat = cpu_wr & ~cpu_addr;
        rd_int  = cpu_rd &  cpu_addr;
        wr_int  = cpu_wr &  cpu_addr;
    end

    i2c_sf_event_sort u_sort (
        .stop_i     (bus_stop),
        .busy_i     (bus_frame_busy),
        .dre_i      (bus_dre),
        .drf_i      (bus_drf),
        .match_i    (bus_addr_match),
        .mode_i     (bus_mode_e'(bus_mode)),
        .err_set_o  (err_set),
        .norm_set_o (norm_set),
        .xfer_set_o (xfer_set)
    );

    // Master interrupt flag: raised with the continuous-transfer flag.
    i2c_sf_flag_cell u_int (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (xfer_set),
        .rd_i      (rd_int),
        .wr_zero_i (wr_int & ~cpu_wdata[INT_BIT]),
        .ext_clr_i (1'b0),
        .flag_o    (int_q),
        .clr_o     (link_clr)
    );

    assign set_vec     = {err_set, norm_set, xfer_set};
    assign ext_clr_vec = {link_clr, link_clr, link_clr & if_enable};

    // Status flags, index i maps to register bit XFER_BIT + i.
    for (genvar i = 0; i < NUM_STAT; i++) begin : g_stat
        i2c_sf_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_vec[i]),
            .rd_i      (rd_stat),
            .wr_zero_i (wr_stat & ~cpu_wdata[XFER_BIT+i]),
            .ext_clr_i (ext_clr_vec[i]),
            .flag_o    (stat_flags[i]),
            .clr_o     (stat_clr[i])
        );
    end

    // Read data multiplexer; unused bits read 0.
    always_comb begin
        cpu_rdata = '0;
        if (!cpu_addr) begin
            cpu_rdata[ERR_BIT:XFER_BIT] = stat_flags;
        end else begin
            cpu_rdata[INT_BIT] = int_q;
        end
    end

    assign int_flag = int_q;
    assign irq_out  = int_q & irq_enable;
endmodule

// File: rtl/i2c_status_flags_chk.sv
// Property checker for i2c_status_flags, bound to every instance.
module i2c_status_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_stop,
    input logic       bus_frame_busy,
    input logic       bus_dre,
    input logic       bus_drf,
    input logic [1:0] bus_mode,
    input logic       irq_enable,
    input logic       cpu_wr,
    input logic       cpu_addr,
    input logic [7:0] cpu_wdata,
    input logic [7:0] cpu_rdata,
    input logic [2:0] stat_flags,
    input logic       int_flag,
    input logic       irq_out
);
    // R2
    err_stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && bus_frame_busy && bus_mode == 2'b00) |=> stat_flags[2]);
    // R3
    norm_stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !bus_frame_busy && bus_mode == 2'b00) |=> stat_flags[1]);
    // R5
    xfer_unqual_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_dre || bus_drf) && bus_mode != 2'b00) |=> stat_flags[0]);
    // R6
    xfer_raises_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_flags[0]) |-> int_flag);
    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flags[2] && !(cpu_wr && !cpu_addr && !cpu_wdata[7])
                       && !(cpu_wr && cpu_addr && !cpu_wdata[0])) |=> stat_flags[2]);
    // R9
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable |-> !irq_out);
    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> int_flag);
    // R10
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr |-> (cpu_rdata[4:0] == 5'd0));
endmodule

bind i2c_status_flags i2c_status_flags_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_stop       (bus_stop),
    .bus_frame_busy (bus_frame_busy),
    .bus_dre        (bus_dre),
    .bus_drf        (bus_drf),
    .bus_mode       (bus_mode),
    .irq_enable     (irq_enable),
    .cpu_wr         (cpu_wr),
    .cpu_addr       (cpu_addr),
    .cpu_wdata      (cpu_wdata),
    .cpu_rdata      (cpu_rdata),
    .stat_flags     (stat_flags),
    .int_flag       (int_q),
    .irq_out        (irq_out)
);

// File: tb/i2c_status_flags_tb.sv
// Bench: directed scenarios plus a behavioural reference compared every clock.
module i2c_status_flags_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_stop = 0, bus_frame_busy = 0, bus_dre = 0, bus_drf = 0, bus_addr_match = 0;
    logic [1:0] bus_mode = 2'b00;
    logic       if_enable = 1'b1, irq_enable = 1'b1;
    logic       cpu_rd = 0, cpu_wr = 0, cpu_addr = 0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       int_flag, irq_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    i2c_status_flags u_dut (
        .clk(clk), .rst_n(rst_n), .bus_stop(bus_stop), .bus_frame_busy(bus_frame_busy),
        .bus_dre(bus_dre), .bus_drf(bus_drf), .bus_addr_match(bus_addr_match),
        .bus_mode(bus_mode), .if_enable(if_enable), .irq_enable(irq_enable),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .int_flag(int_flag), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model state: flags and arms.
    bit m_err, m_norm, m_xfer, m_int;
    bit a_err, a_norm, a_xfer, a_int;

    task automatic step(inout bit f, inout bit a, input bit set, input bit clr, input bit rd);
        bit was;
        was = f;
        if (set) begin
            f = 1;
            if (rd && was) a = 1;
        end else if (was && clr) begin
            f = 0;
            a = 0;
        end else if (rd && was) begin
            a = 1;
        end
    endtask

    always @(posedge clk) begin : ref_model
        bit slave, se, sn, sx, rd0, rd1, int_gone, int_pending;
        if (!rst_n) begin
            {m_err, m_norm, m_xfer, m_int} = 4'b0;
            {a_err, a_norm, a_xfer, a_int} = 4'b0;
        end else begin
            slave = (bus_mode == 2'b00);
            se = bus_stop && slave && bus_frame_busy;
            sn = bus_stop && slave && !bus_frame_busy;
            sx = (bus_dre || bus_drf) && (!slave || bus_addr_match);
            rd0 = cpu_rd && !cpu_addr;
            rd1 = cpu_rd && cpu_addr;
            int_pending = cpu_wr && cpu_addr && !cpu_wdata[0] && a_int;
            int_gone = m_int && !sx && int_pending;
            step(m_int, a_int, sx, int_pending, rd1);
            step(m_err, a_err, se, (cpu_wr && !cpu_addr && !cpu_wdata[7] && a_err) || int_gone, rd0);
            step(m_norm, a_norm, sn, (cpu_wr && !cpu_addr && !cpu_wdata[6] && a_norm) || int_gone, rd0);
            step(m_xfer, a_xfer, sx, (cpu_wr && !cpu_addr && !cpu_wdata[5] && a_xfer) ||
                                     (int_gone && if_enable), rd0);
        end
    end

    // Compare the design against the model on every clock (R1 read data, R9 interrupt).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 per-cycle read data", cpu_rdata,
                  cpu_addr ? {7'b0, m_int} : {m_err, m_norm, m_xfer, 5'b0});
            check("R9 per-cycle irq_out", {7'b0, irq_out}, {7'b0, m_int && irq_enable});
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic peek(input logic a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        cpu_addr = a;
        cpu_rd = 1;
        #1;
        d = cpu_rdata;
        tick();
        cpu_rd = 0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        cpu_addr = a;
        cpu_wr = 1;
        cpu_wdata = d;
        tick();
        cpu_wr = 0;
        cpu_wdata = 8'h00;
    endtask

    task automatic stop_pulse(input logic busy);
        bus_stop = 1;
        bus_frame_busy = busy;
        tick();
        bus_stop = 0;
        bus_frame_busy = 0;
    endtask

    task automatic data_pulse(input logic empty_ev, input logic match);
        bus_dre = empty_ev;
        bus_drf = !empty_ev;
        bus_addr_match = match;
        tick();
        bus_dre = 0;
        bus_drf = 0;
        bus_addr_match = 0;
    endtask

    initial begin : watchdog
        #(100000 * 10);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stimulus
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        peek(0, d); check("R1 reset status", d, 8'h00);
        peek(1, d); check("R1 reset interrupt flag", d, 8'h00);
        check("R9 reset irq_out", {7'b0, irq_out}, 8'h00);

        bus_mode = 2'b00;
        stop_pulse(1);
        peek(0, d); check("R2 error-stop set", d, 8'h80);
        wr(0, 8'h00);
        peek(0, d); check("R4 write 0 without read", d, 8'h80);
        wr(0, 8'hFF);
        peek(0, d); check("R4 write 1 no effect", d, 8'h80);
        rd(0, d); check("R1 strobed read", d, 8'h80);
        wr(0, 8'h00);
        peek(0, d); check("R4 write 0 after read clears", d, 8'h00);

        bus_mode = 2'b01;
        stop_pulse(1);
        peek(0, d); check("R2 stop ignored outside slave mode", d, 8'h00);
        bus_mode = 2'b00;
        stop_pulse(0);
        peek(0, d); check("R3 normal-stop set", d, 8'h40);

        data_pulse(1, 0);
        peek(0, d); check("R5 slave event without match ignored", d, 8'h40);
        peek(1, d); check("R6 no interrupt without transfer flag", d, 8'h00);
        data_pulse(1, 1);
        peek(0, d); check("R5 slave event with match", d, 8'h60);
        peek(1, d); check("R6 interrupt raised with transfer flag", d, 8'h01);

        irq_enable = 0;
        #1 check("R9 irq masked", {7'b0, irq_out}, 8'h00);
        irq_enable = 1;
        #1 check("R9 irq unmasked", {7'b0, irq_out}, 8'h01);

        stop_pulse(1);
        peek(0, d); check("R2 error-stop with others set", d, 8'hE0);
        wr(1, 8'h00);
        peek(1, d); check("R6 interrupt write 0 without read", d, 8'h01);

        if_enable = 0;
        rd(1, d);
        wr(1, 8'h00);
        peek(1, d); check("R6 interrupt cleared after read", d, 8'h00);
        peek(0, d); check("R7 linked clear, transfer kept while disabled", d, 8'h20);
        rd(0, d);
        wr(0, 8'h00);
        peek(0, d); check("R4 transfer flag direct clear", d, 8'h00);

        bus_mode = 2'b10;
        data_pulse(0, 0);
        peek(0, d); check("R5 clocked synchronous unconditional", d, 8'h20);
        peek(1, d); check("R6 interrupt in clocked synchronous mode", d, 8'h01);
        if_enable = 1;
        rd(1, d);
        wr(1, 8'h00);
        peek(0, d); check("R7 linked clear of transfer flag when enabled", d, 8'h00);
        peek(1, d); check("R7 interrupt cleared", d, 8'h00);

        bus_mode = 2'b00;
        stop_pulse(1);
        rd(0, d);
        bus_stop = 1;
        bus_frame_busy = 1;
        wr(0, 8'h00);
        bus_stop = 0;
        bus_frame_busy = 0;
        peek(0, d); check("R8 set wins over direct clear", d, 8'h80);
        wr(0, 8'h00);
        peek(0, d); check("R4 arm kept until flag clears", d, 8'h00);

        bus_mode = 2'b01;
        data_pulse(1, 0);
        rd(1, d);
        bus_dre = 1;
        wr(1, 8'h00);
        bus_dre = 0;
        peek(1, d); check("R8 set wins over interrupt clear", d, 8'h01);
        peek(0, d); check("R8 no linked clear when interrupt held", d, 8'h20);
        wr(1, 8'h00);
        peek(1, d); check("R7 interrupt cleared on retry", d, 8'h00);
        peek(0, d); check("R7 transfer cleared on retry", d, 8'h00);

        bus_mode = 2'b00;
        stop_pulse(1);
        wr(0, 8'h9F);
        peek(0, d); check("R10 low bits ignored and read 0", d, 8'h80);
        wr(1, 8'hFE);
        peek(1, d); check("R10 interrupt register upper bits read 0", d, 8'h00);

        tick();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule